// File: doc/BRIEF.md
# Bunch-Crossing Identifier Keeper with Reset Scheduling

This block keeps a bunch-crossing count aligned with a periodic orbit and publishes a corrected identifier. Each orbit it inserts a multi-cycle counter-reset command into an outgoing serial command line. The reset is placed at a fixed position inside the trigger-free stretch that comes before the first filled bunch. The same line also carries level-1 accepts, one bit per accepted trigger.

A reset burst cannot share the line with a trigger. For that reason the block raises a veto one cycle before the burst's first bit lands on the line. It keeps the veto up through the last bit and one guard cycle after it. Any accept presented while the veto is high is discarded, and a saturating counter records it.

The published identifier is the raw orbit position minus a programmable offset, taken modulo the orbit length. This lets identifier zero line up with the first filled bunch despite the transmission delay of the reset. The raw count restarts from an external orbit marker and also wraps by itself at the end of each orbit.

Top module: `bcid_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the raw count is 0. `veto_o`, `cmd_o` and `cmd_rst_o` are 0, `drop_cnt_o` is 0, and `bcid_o` equals (0 - offset) mod 3564.
- R2: Without an orbit marker, the raw count rises by one per clock and wraps from 3563 to 0.
- R3: An orbit marker sampled high at a clock edge makes the raw count 0 in the following cycle.
- R4: `bcid_o` equals (raw - ofs) mod 3564, where the 12-bit `ofs_i` is first reduced by 3564 when it is 3564 or more. It changes in the same cycle as the raw count or the offset.
- R5: When the raw count equals 3540 and no reset burst is in progress, `veto_o` is high for exactly 5 consecutive cycles. These start in the next cycle.
- R6: The reset burst places the bits 1, 0, 1, 1 on `cmd_o`, in that order, with `cmd_rst_o` high. They occupy the 2nd through 5th cycles of the veto window, and every burst cycle directly follows a vetoed cycle.
- R7: `l1a_i` high in a cycle with `veto_o` low gives `cmd_o`=1 and `cmd_rst_o`=0 in the next cycle. Outside a burst, `cmd_o` is otherwise 0.
- R8: `l1a_i` high in a cycle with `veto_o` high produces no trigger bit on `cmd_o`, and `drop_cnt_o` rises by one in the next cycle.
- R9: `drop_cnt_o` saturates at all ones of its width (16 bits by default) and holds there.
- R10: Once a burst has started, it runs its full 5-cycle veto and all 4 bits even if an orbit marker restarts the raw count in the middle of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous active-high reset |
| orbit_i | input | 1 | Orbit marker; the raw count is 0 in the cycle after it |
| l1a_i | input | 1 | Level-1 accept request |
| ofs_i | input | OFS_W (12) | Identifier offset |
| cmd_o | output | 1 | Serial command line carrying trigger and reset bits |
| cmd_rst_o | output | 1 | High while `cmd_o` carries a reset-burst bit |
| veto_o | output | 1 | Trigger veto; accepts presented now are dropped |
| bcid_o | output | CNT_W (12) | Offset-corrected bunch identifier |
| drop_cnt_o | output | DROP_W (16) | Saturating count of vetoed accepts |

## Verification
The bench targets four corner cases:
- A trigger on the last cycle before the veto rises. It must go out as a trigger; a design that started the veto one cycle late would instead let it collide with the first reset bit.
- Accepts held across the whole veto window. A design that counted off by one, or let a trigger through the guard cycle, would show an extra drop or a stray `cmd_o` pulse after the burst.
- An orbit marker in the middle of a burst. This catches a sequencer slaved to the raw count, which would cut the burst short.
- Offsets above the orbit length, and counter saturation. These catch a missing reduction step, which gives identifiers beyond 3563, and a counter that wraps back to 0.

// File: rtl/bcid_pkg.sv
package bcid_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SEND  = 2'd1,
        SEQ_GUARD = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic bit_v;
        logic is_rst;
    } cmd_word_t;

    // next position on a circular count of length len
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned len);
        return (v + 1 >= len) ? 0 : v + 1;
    endfunction

    // bring a value below 2*len into the range [0, len)
    function automatic int unsigned fold_once(input int unsigned v, input int unsigned len);
        return (v >= len) ? v - len : v;
    endfunction

    // (a - b) mod len for a, b already in [0, len)
    function automatic int unsigned sub_mod(input int unsigned a, input int unsigned b,
                                            input int unsigned len);
        return (a >= b) ? a - b : a + len - b;
    endfunction

endpackage

// File: rtl/bcid_orbit_ctr.sv
module bcid_orbit_ctr #(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = 12,
    parameter int RST_POS   = 3540
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             orbit_i,
    output logic [CNT_W-1:0] raw_o,
    output logic             start_o
);
    import bcid_pkg::*;

    localparam logic [CNT_W-1:0] START_V = CNT_W'(RST_POS);

    logic [CNT_W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst || orbit_i) begin
            raw_q <= '0;
        end else begin
            raw_q <= CNT_W'(wrap_inc(int'(raw_q), ORBIT_LEN));
        end
    end

    assign raw_o   = raw_q;
    assign start_o = (raw_q == START_V);

    AST_ORBIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        orbit_i |=> (raw_q == '0)); // R3
    AST_RAW_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(raw_q) < ORBIT_LEN); // R2

endmodule

// File: rtl/bcid_rst_seq.sv
module bcid_rst_seq #(
    parameter int               RST_LEN   = 4,
    parameter int               GUARD_LEN = 1,
    parameter logic [RST_LEN-1:0] RST_PAT = 4'b1011
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic veto_o,
    output logic send_o,
    output logic send_bit_o
);
    import bcid_pkg::*;

    localparam int IDX_W = $clog2(RST_LEN + GUARD_LEN + 1);
    localparam logic [IDX_W-1:0] LAST_SEND  = IDX_W'(RST_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_GUARD = IDX_W'((GUARD_LEN > 0) ? GUARD_LEN - 1 : 0);

    seq_state_e       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        case (state_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    state_n = SEQ_SEND;
                    idx_n   = '0;
                end
            end
            SEQ_SEND: begin
                if (idx_q == LAST_SEND) begin
                    idx_n   = '0;
                    state_n = (GUARD_LEN > 0) ? SEQ_GUARD : SEQ_IDLE;
                end else begin
                    idx_n = idx_q + 1'b1;
                end
            end
            SEQ_GUARD: begin
                if (idx_q == LAST_GUARD) begin
                    idx_n   = '0;
                    state_n = SEQ_IDLE;
                end else begin
                    idx_n = idx_q + 1'b1;
                end
            end
            default: begin
                state_n = SEQ_IDLE;
                idx_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    // pattern leaves most significant bit first
    always_comb begin
        send_bit_o = 1'b0;
        for (int i = 0; i < RST_LEN; i++) begin
            if (idx_q == IDX_W'(i)) begin
                send_bit_o = RST_PAT[RST_LEN-1-i];
            end
        end
    end

    assign veto_o = (state_q != SEQ_IDLE);
    assign send_o = (state_q == SEQ_SEND);

    AST_VETO_OPENS_WITH_SEND: assert property (@(posedge clk) disable iff (rst)
        $rose(veto_o) |-> send_o); // R5
    AST_SEND_NEEDS_VETO: assert property (@(posedge clk) disable iff (rst)
        send_o |-> veto_o); // R6

endmodule

// File: rtl/bcid_cmd_gate.sv
module bcid_cmd_gate #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l1a_i,
    input  logic              veto_i,
    input  logic              send_i,
    input  logic              send_bit_i,
    output logic              cmd_o,
    output logic              cmd_rst_o,
    output logic [DROP_W-1:0] drop_o
);
    import bcid_pkg::*;

    cmd_word_t         cmd_q;
    logic [DROP_W-1:0] drop_q;
    logic              dropping;

    assign dropping = l1a_i & veto_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (send_i) begin
            cmd_q.bit_v  <= send_bit_i;
            cmd_q.is_rst <= 1'b1;
        end else begin
            cmd_q.bit_v  <= l1a_i & ~veto_i;
            cmd_q.is_rst <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_q <= '0;
        end else if (dropping && (drop_q != '1)) begin
            drop_q <= drop_q + 1'b1;
        end
    end

    assign cmd_o     = cmd_q.bit_v;
    assign cmd_rst_o = cmd_q.is_rst;
    assign drop_o    = drop_q;

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        (l1a_i && veto_i && (drop_q != '1)) |=> (drop_q == $past(drop_q) + 1'b1)); // R8
    AST_DROP_SAT: assert property (@(posedge clk) disable iff (rst)
        (drop_q == '1) |=> (drop_q == '1)); // R9
    AST_TRIG_ECHO: assert property (@(posedge clk) disable iff (rst)
        (cmd_o && !cmd_rst_o) |-> $past(l1a_i && !veto_i)); // R7

endmodule

// File: rtl/bcid_offset.sv
module bcid_offset #(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = 12,
    parameter int OFS_W     = 12
) (
    input  logic [CNT_W-1:0] raw_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [CNT_W-1:0] bcid_o
);
    import bcid_pkg::*;

    int unsigned ofs_red;

    // the reduction is only built when the offset field can reach past an orbit
    generate
        if ((64'd1 << OFS_W) > 64'(ORBIT_LEN)) begin : g_fold
            assign ofs_red = fold_once(int'(ofs_i), ORBIT_LEN);
        end else begin : g_direct
            assign ofs_red = int'(ofs_i);
        end
    endgenerate

    assign bcid_o = CNT_W'(sub_mod(int'(raw_i), ofs_red, ORBIT_LEN));

endmodule

// File: rtl/bcid_sched.sv
module bcid_sched #(
    parameter int                 ORBIT_LEN = 3564,
    parameter int                 RST_POS   = 3540,
    parameter int                 RST_LEN   = 4,
    parameter int                 GUARD_LEN = 1,
    parameter logic [RST_LEN-1:0] RST_PAT   = 4'b1011,
    parameter int                 OFS_W     = 12,
    parameter int                 DROP_W    = 16,
    localparam int                CNT_W     = $clog2(ORBIT_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              orbit_i,
    input  logic              l1a_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic              cmd_o,
    output logic              cmd_rst_o,
    output logic              veto_o,
    output logic [CNT_W-1:0]  bcid_o,
    output logic [DROP_W-1:0] drop_cnt_o
);
    logic [CNT_W-1:0] raw;
    logic             start;
    logic             send;
    logic             send_bit;

    bcid_orbit_ctr #(
        .ORBIT_LEN (ORBIT_LEN),
        .CNT_W     (CNT_W),
        .RST_POS   (RST_POS)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .orbit_i (orbit_i),
        .raw_o   (raw),
        .start_o (start)
    );

    bcid_rst_seq #(
        .RST_LEN   (RST_LEN),
        .GUARD_LEN (GUARD_LEN),
        .RST_PAT   (RST_PAT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .veto_o     (veto_o),
        .send_o     (send),
        .send_bit_o (send_bit)
    );

    bcid_cmd_gate #(
        .DROP_W (DROP_W)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .l1a_i      (l1a_i),
        .veto_i     (veto_o),
        .send_i     (send),
        .send_bit_i (send_bit),
        .cmd_o      (cmd_o),
        .cmd_rst_o  (cmd_rst_o),
        .drop_o     (drop_cnt_o)
    );

    bcid_offset #(
        .ORBIT_LEN (ORBIT_LEN),
        .CNT_W     (CNT_W),
        .OFS_W     (OFS_W)
    ) u_ofs (
        .raw_i  (raw),
        .ofs_i  (ofs_i),
        .bcid_o (bcid_o)
    );

    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        cmd_rst_o |-> $past(veto_o)); // R6
    AST_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(bcid_o) < ORBIT_LEN); // R4

endmodule

// File: tb/bcid_sched_bench.sv
module bcid_sched_bench;

    localparam int ORBIT  = 3564;
    localparam int RPOS   = 3540;
    localparam int DROP_W = 3;
    localparam int DMAX   = (1 << DROP_W) - 1;
    localparam logic [3:0] PAT = 4'b1011;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              orbit_i = 1'b0;
    logic              l1a_i = 1'b0;
    logic [11:0]       ofs_i = '0;
    logic              cmd_o, cmd_rst_o, veto_o;
    logic [11:0]       bcid_o;
    logic [DROP_W-1:0] drop_cnt_o;

    always #4 clk = ~clk;

    bcid_sched #(.DROP_W(DROP_W)) u_bcid_sched (
        .clk        (clk),
        .rst        (rst),
        .orbit_i    (orbit_i),
        .l1a_i      (l1a_i),
        .ofs_i      (ofs_i),
        .cmd_o      (cmd_o),
        .cmd_rst_o  (cmd_rst_o),
        .veto_o     (veto_o),
        .bcid_o     (bcid_o),
        .drop_cnt_o (drop_cnt_o)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    // reference state, derived from the requirements
    int m_raw = 0, m_ph = 0, m_cmd = 0, m_rst = 0, m_drop = 0;

    function automatic int exp_bcid(input int raw, input int ofs);
        int o;
        o = (ofs >= ORBIT) ? ofs - ORBIT : ofs;
        return (raw >= o) ? raw - o : raw + ORBIT - o;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d (bcid model raw=%0d)", tag, act, exp, m_raw);
        end
    endtask

    task automatic model_edge(input logic l1a, input logic orb);
        int veto_old;
        veto_old = (m_ph != 0);
        if (rst) begin
            m_raw = 0; m_ph = 0; m_cmd = 0; m_rst = 0; m_drop = 0;
            return;
        end
        if (m_ph >= 1 && m_ph <= 4) begin
            m_cmd = PAT[4 - m_ph];
            m_rst = 1;
        end else begin
            m_cmd = (l1a && !veto_old) ? 1 : 0;
            m_rst = 0;
        end
        if (l1a && veto_old && m_drop < DMAX) m_drop++;
        if (m_ph == 0) m_ph = (m_raw == RPOS) ? 1 : 0;
        else           m_ph = (m_ph == 5) ? 0 : m_ph + 1;
        if (orb) m_raw = 0;
        else     m_raw = (m_raw == ORBIT - 1) ? 0 : m_raw + 1;
    endtask

    task automatic compare_all();
        chk("R4 bcid", int'(bcid_o), exp_bcid(m_raw, int'(ofs_i)));
        chk("R5 veto", int'(veto_o), (m_ph != 0) ? 1 : 0);
        chk(m_rst ? "R6 cmd" : "R7 cmd", int'(cmd_o), m_cmd);
        chk("R6 cmd_rst", int'(cmd_rst_o), m_rst);
        chk(m_drop == DMAX ? "R9 drop" : "R8 drop", int'(drop_cnt_o), m_drop);
    endtask

    task automatic step(input logic l1a, input logic orb);
        l1a_i   = l1a;
        orbit_i = orb;
        @(posedge clk);
        model_edge(l1a, orb);
        @(negedge clk);
        compare_all();
    endtask

    task automatic run_to(input int raw);
        while (m_raw != raw) step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int vcount;
        logic [3:0] bits;
        int nbits;
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        // R1: reset state, offset 0
        chk("R1 bcid", int'(bcid_o), 0);
        chk("R1 veto", int'(veto_o), 0);
        chk("R1 cmd", int'(cmd_o), 0);
        chk("R1 drop", int'(drop_cnt_o), 0);
        ofs_i = 12'd5;
        #1;
        chk("R1 bcid offset", int'(bcid_o), ORBIT - 5);
        ofs_i = '0;
        rst = 1'b0;
        step(1'b0, 1'b0);
        chk("R2 first count", int'(bcid_o), 1);

        // first orbit: observe veto length and burst bits
        run_to(RPOS);
        vcount = 0; bits = '0; nbits = 0;
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0);
            if (veto_o) vcount++;
            if (cmd_rst_o) begin bits = {bits[2:0], cmd_o}; nbits++; end
        end
        chk("R5 veto cycles", vcount, 5);
        chk("R6 burst bits", int'(bits), int'(PAT));
        chk("R6 burst len", nbits, 4);
        run_to(ORBIT - 1);
        chk("R2 last", int'(bcid_o), ORBIT - 1);
        step(1'b0, 1'b0);
        chk("R2 wrap", int'(bcid_o), 0);

        // trigger just before veto, then accepts held through the window
        run_to(RPOS);
        step(1'b1, 1'b0);
        chk("R7 trigger out", int'(cmd_o), 1);
        chk("R7 not reset", int'(cmd_rst_o), 0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R8 drops", int'(drop_cnt_o), 5);
        chk("R8 no stray trigger", int'(cmd_o), 0);

        // orbit marker in the middle of a burst
        run_to(RPOS + 1);
        chk("R10 veto open", int'(veto_o), 1);
        step(1'b0, 1'b1);
        chk("R3 orbit zero", int'(bcid_o), 0);
        chk("R10 veto held", int'(veto_o), 1);
        nbits = 0;
        if (cmd_rst_o) nbits++;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0);
            if (cmd_rst_o) nbits++;
        end
        chk("R10 veto end", int'(veto_o), 1);
        step(1'b0, 1'b0);
        if (cmd_rst_o) nbits++;
        chk("R10 released", int'(veto_o), 0);
        chk("R10 full burst", nbits, 4);

        // offset handling
        ofs_i = 12'd100;
        step(1'b0, 1'b0);
        chk("R4 small ofs", int'(bcid_o), exp_bcid(m_raw, 100));
        ofs_i = 12'd4000;
        step(1'b0, 1'b0);
        chk("R4 folded ofs", int'(bcid_o), exp_bcid(m_raw, 436));
        ofs_i = '0;

        // saturation of the drop counter
        run_to(RPOS + 1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R9 saturated", int'(drop_cnt_o), DMAX);

        // mixed random stimulus
        for (int i = 0; i < 45000; i++) begin
            logic l1a, orb;
            l1a = ($urandom % 4) == 0;
            if (m_raw == ORBIT - 1) orb = ($urandom % 8) != 0;
            else                    orb = ($urandom % 6000) == 0;
            if (($urandom % 3000) == 0) ofs_i = 12'($urandom % 4096);
            step(l1a, orb);
        end
        chk("R9 still saturated", int'(drop_cnt_o), DMAX);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule